// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the combinational integer execution stage of a 32-bit load/store RISC core. In one cycle it takes the rs and rt register values, the raw 16-bit immediate, a 5-bit shift-amount field and a compact 5-bit operation select. It returns the 32-bit result, an overflow-trap flag and a write-enable for the destination register.

Each operation carries its own operand policy. The block widens the immediate itself: by sign extension, by zero extension, or by placing it in the upper half of the word. It also decides whether a two's complement overflow must trap. When a trap is raised, the write-enable drops, so the destination register keeps its old value and the core can take the exception.

The block has no state and no clock. It has no state machine: every output is a pure function of the current inputs.

Top module: `alu_exec_unit`

## Requirements
- R1: `op_sel` encodings are: 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 ADDI, 5 ADDIU, 6 AND, 7 OR, 8 XOR, 9 NOR, 10 ANDI, 11 ORI, 12 XORI, 13 SLT, 14 SLTU, 15 SLTI, 16 SLTIU, 17 LUI, 18 SLL, 19 SRL, 20 SRA, 21 SLLV, 22 SRLV, 23 SRAV; codes 24 to 31 are unused.
- R2: ADD, ADDU, SUB and SUBU return rs+rt or rs-rt modulo 2^32.
- R3: `ovf_trap` is 1 for ADD, SUB and ADDI exactly when the true signed result lies outside [-2^31, 2^31-1]; it is always 0 for every other code, including ADDU, SUBU and ADDIU.
- R4: `wr_en` is 1 for every used code unless `ovf_trap` is 1, in which case it is 0.
- R5: ADDI, ADDIU, SLTI and SLTIU use the immediate sign-extended from bit 15 as the second operand.
- R6: ANDI, ORI and XORI use the immediate zero-extended to 32 bits.
- R7: AND, OR, XOR and NOR combine rs and rt bitwise; NOR returns the inverted OR.
- R8: SLT and SLTI return 1 when rs is less than the second operand taken as signed values, else 0.
- R9: SLTU and SLTIU compare as unsigned values and return 1 or 0; SLTIU compares against the sign-extended immediate.
- R10: LUI returns the immediate in bits 31:16 and zeros in bits 15:0.
- R11: SLL, SRL and SRA shift rt by `shamt`: logically left, logically right, or right with the sign bit replicated.
- R12: SLLV, SRLV and SRAV shift rt the same way, by the distance held in rs bits 4:0; the other rs bits are ignored.
- R13: For unused codes, `result` is 0, `ovf_trap` is 0 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation select (encodings in R1) |
| rs_val | input | 32 | First register operand; shift distance for variable shifts |
| rt_val | input | 32 | Second register operand; shifted value |
| imm16 | input | 16 | Raw immediate field |
| shamt | input | 5 | Fixed shift distance |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow exception |
| wr_en | output | 1 | Destination write enable |

## Verification
The hardest cases to reach from the ports sit at the exact edges of the signed range. One is a sum that lands one step past 2^31-1 or below -2^31. Another is an SLTIU whose immediate has bit 15 set, so it becomes a very large unsigned value. The stimulus walks a grid of corner operands (0, 1, the largest positive value, the most negative value, all ones and their neighbours) against immediates 0x7FFF, 0x8000 and 0xFFFF, across all 32 codes. Every overflow boundary and every sign-extension boundary is therefore hit directly. The expected results come from wide signed arithmetic computed in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_ADDI  = 5'd4,
        OP_ADDIU = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_NOR   = 5'd9,
        OP_ANDI  = 5'd10,
        OP_ORI   = 5'd11,
        OP_XORI  = 5'd12,
        OP_SLT   = 5'd13,
        OP_SLTU  = 5'd14,
        OP_SLTI  = 5'd15,
        OP_SLTIU = 5'd16,
        OP_LUI   = 5'd17,
        OP_SLL   = 5'd18,
        OP_SRL   = 5'd19,
        OP_SRA   = 5'd20,
        OP_SLLV  = 5'd21,
        OP_SRLV  = 5'd22,
        OP_SRAV  = 5'd23
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_mode_e;

    typedef enum logic [2:0] {
        GRP_NONE  = 3'd0,
        GRP_ARITH = 3'd1,
        GRP_LOGIC = 3'd2,
        GRP_SLT   = 3'd3,
        GRP_SLTU  = 3'd4,
        GRP_LUI   = 3'd5,
        GRP_SHIFT = 3'd6
    } grp_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_e;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_RL = 2'd1,
        SH_RA = 2'd2
    } shift_e;

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext
    import alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm,
    input  ext_mode_e        mode,
    output logic [XLEN-1:0]  ext_out
);
    localparam int PAD = XLEN - IMM_W;

    always_comb begin
        unique case (mode)
            EXT_SIGN:  ext_out = {{PAD{imm[IMM_W-1]}}, imm};
            EXT_ZERO:  ext_out = {{PAD{1'b0}}, imm};
            EXT_UPPER: ext_out = {imm, {PAD{1'b0}}};
            default:   ext_out = '0;
        endcase
    end

    always_comb begin
        // R10
        upper_low_zero_chk: assert (!(mode == EXT_UPPER) || ext_out[PAD-1:0] == '0)
            else $error("upper placement left low bits set");
        // R6
        zero_ext_top_chk: assert (!(mode == EXT_ZERO) || ext_out[XLEN-1:IMM_W] == '0)
            else $error("zero extension left high bits set");
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] sum,
    output logic            ovf_raw,
    output logic            lt_s,
    output logic            lt_u
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   full;

    always_comb begin
        b_eff   = sub ? ~b : b;
        full    = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
        sum     = full[XLEN-1:0];
        ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        lt_s    = sum[MSB] ^ ovf_raw;
        lt_u    = ~full[XLEN];
    end

    always_comb begin
        // R8
        equal_not_less_chk: assert (!(sub && a == b) || (!lt_s && !lt_u))
            else $error("equal operands reported as less");
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] data,
    input  logic [SH_W-1:0] amt,
    input  shift_e          kind,
    output logic [XLEN-1:0] dout
);
    logic            left;
    logic            fill;
    logic [XLEN-1:0] data_rev;
    logic [XLEN-1:0] src;
    logic [XLEN-1:0] out_rev;
    logic [XLEN-1:0] stg [SH_W+1];

    assign left = (kind == SH_LL);
    assign fill = (kind == SH_RA) ? data[XLEN-1] : 1'b0;

    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign data_rev[i] = data[XLEN-1-i];
        assign out_rev[i]  = stg[SH_W][XLEN-1-i];
    end

    assign src    = left ? data_rev : data;
    assign stg[0] = src;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][XLEN-1:D]} : stg[k];
    end

    assign dout = left ? out_rev : stg[SH_W];

    always_comb begin
        // R11
        zero_dist_chk: assert (!(amt == '0) || dout == data)
            else $error("zero shift changed the value");
    end

endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
    import alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic [4:0]       op_sel,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [IMM_W-1:0] imm16,
    input  logic [SH_W-1:0]  shamt,
    output logic [XLEN-1:0]  result,
    output logic             ovf_trap,
    output logic             wr_en
);
    alu_op_e   op;
    grp_e      grp;
    ext_mode_e ext_mode;
    logic_e    lg_kind;
    shift_e    sh_kind;
    logic      use_imm;
    logic      do_sub;
    logic      trap_en;
    logic      var_sh;

    logic [XLEN-1:0] ext_val;
    logic [XLEN-1:0] b_opnd;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] sh_out;
    logic [XLEN-1:0] lg_out;
    logic [SH_W-1:0] sh_amt;
    logic            ovf_raw;
    logic            lt_s;
    logic            lt_u;

    assign op = alu_op_e'(op_sel);

    // operation decode
    always_comb begin
        grp      = GRP_NONE;
        ext_mode = EXT_SIGN;
        lg_kind  = LG_AND;
        sh_kind  = SH_LL;
        use_imm  = 1'b0;
        do_sub   = 1'b0;
        trap_en  = 1'b0;
        var_sh   = 1'b0;
        unique case (op)
            OP_ADD:   begin grp = GRP_ARITH; trap_en = 1'b1; end
            OP_ADDU:  begin grp = GRP_ARITH; end
            OP_SUB:   begin grp = GRP_ARITH; do_sub = 1'b1; trap_en = 1'b1; end
            OP_SUBU:  begin grp = GRP_ARITH; do_sub = 1'b1; end
            OP_ADDI:  begin grp = GRP_ARITH; use_imm = 1'b1; trap_en = 1'b1; end
            OP_ADDIU: begin grp = GRP_ARITH; use_imm = 1'b1; end
            OP_AND:   begin grp = GRP_LOGIC; lg_kind = LG_AND; end
            OP_OR:    begin grp = GRP_LOGIC; lg_kind = LG_OR; end
            OP_XOR:   begin grp = GRP_LOGIC; lg_kind = LG_XOR; end
            OP_NOR:   begin grp = GRP_LOGIC; lg_kind = LG_NOR; end
            OP_ANDI:  begin grp = GRP_LOGIC; lg_kind = LG_AND; use_imm = 1'b1; ext_mode = EXT_ZERO; end
            OP_ORI:   begin grp = GRP_LOGIC; lg_kind = LG_OR;  use_imm = 1'b1; ext_mode = EXT_ZERO; end
            OP_XORI:  begin grp = GRP_LOGIC; lg_kind = LG_XOR; use_imm = 1'b1; ext_mode = EXT_ZERO; end
            OP_SLT:   begin grp = GRP_SLT;  do_sub = 1'b1; end
            OP_SLTU:  begin grp = GRP_SLTU; do_sub = 1'b1; end
            OP_SLTI:  begin grp = GRP_SLT;  do_sub = 1'b1; use_imm = 1'b1; end
            OP_SLTIU: begin grp = GRP_SLTU; do_sub = 1'b1; use_imm = 1'b1; end
            OP_LUI:   begin grp = GRP_LUI;  ext_mode = EXT_UPPER; end
            OP_SLL:   begin grp = GRP_SHIFT; sh_kind = SH_LL; end
            OP_SRL:   begin grp = GRP_SHIFT; sh_kind = SH_RL; end
            OP_SRA:   begin grp = GRP_SHIFT; sh_kind = SH_RA; end
            OP_SLLV:  begin grp = GRP_SHIFT; sh_kind = SH_LL; var_sh = 1'b1; end
            OP_SRLV:  begin grp = GRP_SHIFT; sh_kind = SH_RL; var_sh = 1'b1; end
            OP_SRAV:  begin grp = GRP_SHIFT; sh_kind = SH_RA; var_sh = 1'b1; end
            default:  begin grp = GRP_NONE; end
        endcase
    end

    alu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
        .imm     (imm16),
        .mode    (ext_mode),
        .ext_out (ext_val)
    );

    assign b_opnd = use_imm ? ext_val : rt_val;

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a       (rs_val),
        .b       (b_opnd),
        .sub     (do_sub),
        .sum     (sum),
        .ovf_raw (ovf_raw),
        .lt_s    (lt_s),
        .lt_u    (lt_u)
    );

    assign sh_amt = var_sh ? rs_val[SH_W-1:0] : shamt;

    alu_shifter #(.XLEN(XLEN)) u_shift (
        .data (rt_val),
        .amt  (sh_amt),
        .kind (sh_kind),
        .dout (sh_out)
    );

    always_comb begin
        unique case (lg_kind)
            LG_AND:  lg_out = rs_val & b_opnd;
            LG_OR:   lg_out = rs_val | b_opnd;
            LG_XOR:  lg_out = rs_val ^ b_opnd;
            LG_NOR:  lg_out = ~(rs_val | b_opnd);
            default: lg_out = '0;
        endcase
    end

    // result select and trap policy
    always_comb begin
        unique case (grp)
            GRP_ARITH: result = sum;
            GRP_LOGIC: result = lg_out;
            GRP_SLT:   result = {{(XLEN-1){1'b0}}, lt_s};
            GRP_SLTU:  result = {{(XLEN-1){1'b0}}, lt_u};
            GRP_LUI:   result = ext_val;
            GRP_SHIFT: result = sh_out;
            default:   result = '0;
        endcase
        ovf_trap = trap_en & ovf_raw;
        wr_en    = (grp != GRP_NONE) && !ovf_trap;
    end

    always_comb begin
        // R4
        wren_ovf_chk: assert (!(ovf_trap && wr_en))
            else $error("write enabled during overflow trap");
        // R3
        no_overflow_chk: assert (!(op_sel == 5'd1 || op_sel == 5'd3 || op_sel == 5'd5 ||
                                   op_sel > 5'd5) || !ovf_trap)
            else $error("trap raised by a non-trapping code");
        // R8
        slt_bool_chk: assert (!(op_sel >= 5'd13 && op_sel <= 5'd16) || result[XLEN-1:1] == '0)
            else $error("compare result not 0 or 1");
        // R13
        unused_quiet_chk: assert (!(op_sel > 5'd23) || (result == '0 && !wr_en && !ovf_trap))
            else $error("unused code produced activity");
    end

endmodule

// File: tb/sim_alu_exec_unit.sv
module sim_alu_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf_trap;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_exec_unit u0 (
        .op_sel   (op_sel),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .imm16    (imm16),
        .shamt    (shamt),
        .result   (result),
        .ovf_trap (ovf_trap),
        .wr_en    (wr_en)
    );

    function automatic bit out_of_range(input longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    function automatic void model(input int op, input logic [31:0] a, input logic [31:0] b,
                                  input logic [15:0] im, input logic [4:0] sh,
                                  output logic [31:0] r, output bit ov, output bit we);
        logic [31:0]        sx;
        logic [31:0]        zx;
        logic signed [31:0] bs;
        longint             sa;
        longint             sb;
        longint             si;
        sx = {{16{im[15]}}, im};
        zx = {16'h0000, im};
        bs = b;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        si = longint'($signed(sx));
        ov = 1'b0;
        we = 1'b1;
        case (op)
            0:  begin r = a + b;  ov = out_of_range(sa + sb); end
            1:  r = a + b;
            2:  begin r = a - b;  ov = out_of_range(sa - sb); end
            3:  r = a - b;
            4:  begin r = a + sx; ov = out_of_range(sa + si); end
            5:  r = a + sx;
            6:  r = a & b;
            7:  r = a | b;
            8:  r = a ^ b;
            9:  r = ~(a | b);
            10: r = a & zx;
            11: r = a | zx;
            12: r = a ^ zx;
            13: r = (sa < sb) ? 32'd1 : 32'd0;
            14: r = (a < b) ? 32'd1 : 32'd0;
            15: r = (sa < si) ? 32'd1 : 32'd0;
            16: r = (a < sx) ? 32'd1 : 32'd0;
            17: r = {im, 16'h0000};
            18: r = b << sh;
            19: r = b >> sh;
            20: r = bs >>> sh;
            21: r = b << a[4:0];
            22: r = b >> a[4:0];
            23: r = bs >>> a[4:0];
            default: begin r = '0; we = 1'b0; end
        endcase
        if (ov) we = 1'b0;
    endfunction

    function automatic string tag_of(input int op);
        if (op <= 3)  return "R1,R2";
        if (op <= 5)  return "R1,R5";
        if (op <= 9)  return "R7";
        if (op <= 12) return "R6";
        if (op == 13) return "R8";
        if (op == 14) return "R9";
        if (op == 15) return "R5,R8";
        if (op == 16) return "R5,R9";
        if (op == 17) return "R10";
        if (op <= 20) return "R11";
        if (op <= 23) return "R12";
        return "R13";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%h b=%h imm=%h sh=%0d actual=%h expected=%h",
                     tag, what, op_sel, rs_val, rt_val, imm16, shamt, act, exp);
        end
    endtask

    logic [31:0] vals [12] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h7FFF_FFFF,
                               32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE,
                               32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_001F, 32'hFFFF_8000};
    logic [15:0] imms [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
    logic [4:0]  shs  [4] = '{5'd0, 5'd1, 5'd17, 5'd31};

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] er;
        bit          eo;
        bit          ew;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 idle state: ADD of zeros
        check("R2", "reset result", result, 32'h0);
        check("R3", "reset ovf", {31'b0, ovf_trap}, 32'h0);
        check("R4", "reset wr_en", {31'b0, wr_en}, 32'h1);

        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 12; j++) begin
                    for (int k = 0; k < 4; k++) begin
                        @(posedge clk);
                        op_sel = 5'(op);
                        rs_val = vals[i];
                        rt_val = vals[j];
                        imm16  = imms[k];
                        shamt  = shs[k];
                        @(negedge clk);
                        model(op, vals[i], vals[j], imms[k], shs[k], er, eo, ew);
                        check(tag_of(op), "result", result, er);
                        check((op > 23) ? "R13" : "R3", "ovf_trap", {31'b0, ovf_trap}, {31'b0, eo});
                        check((op > 23) ? "R13" : "R4", "wr_en", {31'b0, wr_en}, {31'b0, ew});
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule